// File: doc/BRIEF.md
# Variable-Group Carry-Select Adder

This block is a purely combinational 32-bit adder that takes two operands and a carry-in and returns a 32-bit sum and a carry-out. The operand bits are split into nine contiguous groups. Counting from the least significant end, the groups hold 1, 1, 2, 3, 4, 5, 6, 7 and 3 bits.

Each group above the first works out two full answers at the same time, one for each possible incoming carry. Both answers come from a plain ripple chain, and the two chains share one set of propagate and generate terms. When the true carry into the group arrives from the select chain, it picks one of the two answers. The group's own outgoing carry is formed as the carry-0 result ORed with the carry-1 result gated by the incoming carry.

The group sizes grow towards the top of the word. This keeps the ripple time inside a group close to the time the select chain takes to reach that group. The lowest group is a single bit and rides on the real carry-in directly, so it has no duplicate rail. The sizes are a parameter array, and elaboration stops with an error if they do not add up to the operand width.

Top module: `vgsel_adder`

## Requirements
- R1: For every input, the value {carry_out, sum} equals a + b + carry_in, computed as a 33-bit unsigned value.
- R2: A carry entering at bit 0 travels through every group. With a = 0xFFFFFFFF, b = 0 and carry_in = 1, the sum is 0 and carry_out is 1. The same holds with a and b swapped.
- R3: A carry generated at the most significant bit of any group reaches the following groups. For each group g, set bit hi(g) in both a and b, where hi(g) is the group's top bit (0, 1, 3, 6, 10, 15, 21, 28, 31). Set a to ones above hi(g) and b to zeros there. The result then matches a + b + carry_in, with either value of carry_in.
- R4: With carry_in = 0 the result is a + b. With a = b = 0, carry_in = 0 gives sum 0 and carry_out 0, and carry_in = 1 gives sum 1 and carry_out 0.
- R5: For fixed a and b, if carry_out is 1 with carry_in = 0, then carry_out is also 1 with carry_in = 1.
- R6: With a = b = 0xFFFFFFFF and carry_in = 1, the sum is 0xFFFFFFFF and carry_out is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a | input | 32 | First operand |
| b | input | 32 | Second operand |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 32 | Sum bits |
| carry_out | output | 1 | Carry out of bit 31 |

## Verification
The bench targets a carry that must cross all nine select points.

- **Wrong carry-out merge or a rail mux polarity flipped.** A wrong merge term, or a mux that selects the wrong rail, leaves zeros or stale bits in the upper groups when a = all ones and carry_in = 1.
- **Group boundary slice off by one.** Carries generated at each group's top bit show this up. The carry is then dropped, or it lands one group too high.
- **Lowest bits.** An exhaustive sweep of the low six bits of both operands, with both carry-in values, covers the single-bit groups and the first multi-bit groups.
- **Random vectors.** These catch any rail or mux fault the directed patterns miss, including a rail that ignores its fixed carry.

// File: rtl/vgsel_pkg.sv
// Package: shared defaults and the group carry merge for the variable-group
// carry-select adder. Assumes a carry-0 rail never carries when the
// carry-1 rail does not.
package vgsel_pkg;

    localparam int VG_WIDTH = 32;
    localparam int VG_NGRP  = 9;

    // Merge the two speculative carries of a group using the true carry-in.
    function automatic logic merge_carry(input logic c_if0, input logic c_if1,
                                         input logic c_true);
        return c_if0 | (c_if1 & c_true);
    endfunction

endpackage

// File: rtl/vgsel_ripple.sv
// Module: ripple chain of K positions driven by precomputed propagate and
// generate terms. Assumes p = a ^ b and g = a & b for each position, so the
// sum bit is the propagate term XOR the carry into that position.
module vgsel_ripple #(
    parameter int K = 4
) (
    input  logic [K-1:0] p,
    input  logic [K-1:0] g,
    input  logic         cin,
    output logic [K-1:0] s,
    output logic         cout
);

    logic [K:0] c;

    // Carry ripple through each position, then form the sum bits.
    always_comb begin
        c[0] = cin;
        for (int i = 0; i < K; i++) begin
            c[i+1] = g[i] | (p[i] & c[i]);
        end
        s    = p ^ c[K-1:0];
        cout = c[K];
    end

endmodule

// File: rtl/vgsel_group.sv
// Module: one carry-select group of K bits. It builds two ripple rails, one
// with an assumed carry-in of 0 and one with 1, on shared propagate and
// generate terms. The true carry then picks the sum, and the outgoing carry
// is merged from both rails. Assumes cin settles after the local rails.
module vgsel_group
    import vgsel_pkg::*;
#(
    parameter int K = 4
) (
    input  logic [K-1:0] a,
    input  logic [K-1:0] b,
    input  logic         cin,
    output logic [K-1:0] s,
    output logic         cout
);

    logic [K-1:0] p_sh;
    logic [K-1:0] g_sh;
    logic [K-1:0] s_r0;
    logic [K-1:0] s_r1;
    logic         c_r0;
    logic         c_r1;

    // Per-position propagate and generate, shared by both rails.
    always_comb begin
        p_sh = a ^ b;
        g_sh = a & b;
    end

    vgsel_ripple #(.K(K)) u_rail0 (
        .p   (p_sh),
        .g   (g_sh),
        .cin (1'b0),
        .s   (s_r0),
        .cout(c_r0)
    );

    vgsel_ripple #(.K(K)) u_rail1 (
        .p   (p_sh),
        .g   (g_sh),
        .cin (1'b1),
        .s   (s_r1),
        .cout(c_r1)
    );

    // Select the rail that matches the true carry and merge the carry-out.
    always_comb begin
        s    = cin ? s_r1 : s_r0;
        cout = merge_carry(c_r0, c_r1, cin);
    end

    // Rail consistency checks on settled values.
    always_comb begin
        a_r5_rail_implies: assert (!(c_r0 && !c_r1))
            else $error("carry-0 rail carries while carry-1 rail does not");
        a_r1_rail_step: assert ({c_r1, s_r1} == ({c_r0, s_r0} + (K+1)'(1)))
            else $error("carry-1 rail is not carry-0 rail plus one");
    end

endmodule

// File: rtl/vgsel_adder.sv
// Module: 32-bit carry-select adder with variable group sizes.
// The groups, listed from the LSB, are set by GSZ. Group 0 ripples directly
// on carry_in, and every later group is a two-rail select group. Assumes the
// GSZ entries add up to WIDTH, which is checked at elaboration.
module vgsel_adder
    import vgsel_pkg::*;
#(
    parameter int WIDTH = VG_WIDTH,
    parameter int NGRP  = VG_NGRP,
    parameter int GSZ [NGRP] = '{1, 1, 2, 3, 4, 5, 6, 7, 3}
) (
    input  logic [WIDTH-1:0] a,
    input  logic [WIDTH-1:0] b,
    input  logic             carry_in,
    output logic [WIDTH-1:0] sum,
    output logic             carry_out
);

    // Lowest bit position of group gi: the sum of all sizes below it.
    function automatic int grp_lsb(input int gi);
        int acc;
        acc = 0;
        for (int k = 0; k < gi; k++) begin
            acc += GSZ[k];
        end
        return acc;
    endfunction

    localparam int TOTAL = grp_lsb(NGRP);

    if (TOTAL != WIDTH) begin : g_size_check
        $error("group sizes do not add up to WIDTH");
    end

    logic [NGRP:0] gc;

    assign gc[0]     = carry_in;
    assign carry_out = gc[NGRP];

    for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
        localparam int LSB = grp_lsb(gi);
        localparam int K   = GSZ[gi];

        if (gi == 0) begin : g_direct
            logic [K-1:0] p0;
            logic [K-1:0] g0;

            // Lowest group: plain ripple on the real carry-in.
            always_comb begin
                p0 = a[LSB +: K] ^ b[LSB +: K];
                g0 = a[LSB +: K] & b[LSB +: K];
            end

            vgsel_ripple #(.K(K)) u_rip (
                .p   (p0),
                .g   (g0),
                .cin (gc[gi]),
                .s   (sum[LSB +: K]),
                .cout(gc[gi+1])
            );
        end else begin : g_select
            vgsel_group #(.K(K)) u_grp (
                .a   (a[LSB +: K]),
                .b   (b[LSB +: K]),
                .cin (gc[gi]),
                .s   (sum[LSB +: K]),
                .cout(gc[gi+1])
            );
        end
    end

    // Port-level checks against arithmetic on settled values.
    always_comb begin
        a_r1_sum_matches: assert ({carry_out, sum} ==
                ({1'b0, a} + {1'b0, b} + {{WIDTH{1'b0}}, carry_in}))
            else $error("sum differs from a + b + carry_in");
        a_r2_full_chain: assert (!((a == ~b) && carry_in) ||
                ((sum == '0) && carry_out))
            else $error("full-length carry did not reach the top");
        a_r6_max_operands: assert (!((a == '1) && (b == '1) && carry_in) ||
                ((sum == '1) && carry_out))
            else $error("maximum operands give a wrong result");
        a_r4_zero_in: assert (!((a == '0) && (b == '0)) ||
                ((sum == {{(WIDTH-1){1'b0}}, carry_in}) && !carry_out))
            else $error("zero operands give a wrong result");
    end

endmodule

// File: tb/sim_vgsel_adder.sv
// Bench for vgsel_adder. The adder has no clock; the bench clock only paces
// stimulus. Inputs change on the falling edge and outputs are read 2 ns later.
module sim_vgsel_adder;

    logic        clk;
    logic        rst_n;
    logic [31:0] a;
    logic [31:0] b;
    logic        carry_in;
    logic [31:0] sum;
    logic        carry_out;

    int checks;
    int errors;
    bit done;

    vgsel_adder u0 (
        .a        (a),
        .b        (b),
        .carry_in (carry_in),
        .sum      (sum),
        .carry_out(carry_out)
    );

    // 125 MHz clock
    initial begin
        clk = 1'b0;
        forever #4 clk = ~clk;
    end

    // Watchdog: an expired run counts as one failed check
    initial begin
        #(8 * 190000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Compare a 33-bit result and count the check
    task automatic check(input string req, input logic [32:0] act,
                         input logic [32:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: a=%h b=%h cin=%0d actual=%h expected=%h",
                     req, a, b, carry_in, act, exp);
        end
    endtask

    // Drive one vector and return the settled {carry_out, sum}
    task automatic apply(input logic [31:0] va, input logic [31:0] vb,
                         input logic vc, output logic [32:0] res);
        @(negedge clk);
        a        = va;
        b        = vb;
        carry_in = vc;
        #2;
        res = {carry_out, sum};
    endtask

    // Drive one vector and check it against the arithmetic expectation
    task automatic run(input string req, input logic [31:0] va,
                       input logic [31:0] vb, input logic vc);
        logic [32:0] res;
        logic [32:0] exp;
        apply(va, vb, vc, res);
        exp = {1'b0, va} + {1'b0, vb} + {32'd0, vc};
        check(req, res, exp);
    endtask

    initial begin
        int          gsz [9] = '{1, 1, 2, 3, 4, 5, 6, 7, 3};
        int          hi;
        logic [32:0] r0;
        logic [32:0] r1;
        logic [31:0] ra;
        logic [31:0] rb;
        logic [31:0] lowm;

        checks   = 0;
        errors   = 0;
        done     = 1'b0;
        rst_n    = 1'b0;
        a        = '0;
        b        = '0;
        carry_in = 1'b0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;

        // R4: state with all inputs at zero, then carry-in alone
        @(negedge clk);
        #2;
        check("R4 idle", {carry_out, sum}, 33'd0);
        apply(32'd0, 32'd0, 1'b1, r0);
        check("R4 cin only", r0, 33'd1);

        // R2: carry from bit 0 across all groups, both operand orders
        apply(32'hFFFF_FFFF, 32'd0, 1'b1, r0);
        check("R2 a ones", r0, {1'b1, 32'd0});
        apply(32'd0, 32'hFFFF_FFFF, 1'b1, r0);
        check("R2 b ones", r0, {1'b1, 32'd0});

        // R6: maximum operands with carry-in
        apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 1'b1, r0);
        check("R6 max", r0, {1'b1, 32'hFFFF_FFFF});

        // R3: carry generated at the top bit of each group
        hi = -1;
        for (int g = 0; g < 9; g++) begin
            hi += gsz[g];
            lowm = (hi == 0) ? 32'd0 : ((32'd1 << hi) - 32'd1);
            for (int c = 0; c < 2; c++) begin
                ra = (32'hFFFF_FFFF << hi) | ($urandom & lowm);
                rb = (32'd1 << hi) | ($urandom & lowm);
                run("R3 boundary", ra, rb, c[0]);
            end
        end

        // R1/R4: exhaustive low six bits, upper bits of a all ones
        for (int i = 0; i < 64; i++) begin
            for (int j = 0; j < 64; j++) begin
                run("R4 low sweep", 32'hFFFF_FFC0 | i, j, 1'b0);
                run("R1 low sweep", 32'hFFFF_FFC0 | i, j, 1'b1);
            end
        end

        // R1/R5: random vectors, both carry-in values
        for (int n = 0; n < 3000; n++) begin
            ra = $urandom;
            rb = $urandom;
            apply(ra, rb, 1'b0, r0);
            check("R1 random cin0", r0, {1'b0, ra} + {1'b0, rb});
            apply(ra, rb, 1'b1, r1);
            check("R1 random cin1", r1, {1'b0, ra} + {1'b0, rb} + 33'd1);
            checks++;
            if (r0[32] && !r1[32]) begin
                errors++;
                $display("FAIL R5: a=%h b=%h actual=%0d%0d expected=implied",
                         ra, rb, r0[32], r1[32]);
            end
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule